// File: doc/BRIEF.md
# Chained Double-Window DMA Channel

This block is one DMA channel. It moves 32-bit words between a memory request port and a peripheral stream port, in either direction. Software describes the work as address windows. The active window is a pointer plus an exclusive limit. One more window, a start and a stop, can wait behind it. When the active window runs out and a queued window is marked valid, the channel takes the queued window in the same cycle and goes on. It raises a completion flag and an interrupt, and it keeps copies of the window that just closed. When a received stream ends early, software can read the copies and work out how much data actually arrived.

Software controls the channel through ten 32-bit registers. A typical sequence is:

1. Write the control register with reset, buffer-init and the direction.
2. Load the pointer, limit, start and stop.
3. Write set-enable. Add set-queue-valid to this write when a second window is loaded.

While the channel runs, each interrupt is acknowledged with a clear-done write. Software can add set-queue-valid to that write to chain one more window. Bit 31 of a limit or stop value is a flag carried beside the address. On transmit, it marks the window's final word on the stream.

The engine is a six-state machine:

- **IDLE** waits for enable. It goes to FETCH (memory to device), to PULL (device to memory), or to WRAP when the window is already empty.
- **FETCH** holds a memory read until it is acknowledged, then goes to PUSH. A bus error sends it back to IDLE.
- **PUSH** offers the word to the peripheral. It goes to FETCH, or to WRAP after the window's final word.
- **PULL** waits for a peripheral word, then goes to STORE.
- **STORE** holds a memory write until it is acknowledged. It goes to PULL, or to WRAP on the final word or on an end-of-packet marker. A bus error sends it back to IDLE.
- **WRAP** closes the window. It goes straight to FETCH or PULL when a non-empty queued window is taken, and to IDLE otherwise.

A reset or buffer-init control write sends any state to IDLE.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset every register reads zero, `irq` is low, and no memory or stream request is active.
- R2: Writes to the pointer (offset 2), limit (3), start (4) and stop (5) force address bits 3:0 to zero, so windows are 16-byte aligned. Limit and stop keep bit 31. Pointer and start force bit 31 to zero.
- R3: In memory-to-device mode (control bit 0 = 1), words are read at ascending addresses in steps of 4. Reading starts at the pointer and stops before the limit, comparing bits 30:0 only. Each word is delivered on the stream in order. A memory request holds its address until it is acknowledged.
- R4: When a window ends with the queue-valid bit set, start and stop become the pointer and limit, and queue-valid clears. If the new window is not empty, the first transfer state of that window follows WRAP on the next cycle.
- R5: When a window ends with queue-valid clear, enable clears, queue-valid reads clear, and the channel stops.
- R6: Done (status bit 3) is set at every window end, and `irq` follows it. A control write with bit 3 set clears it. Queue-valid (control bit 2) is set-only: a control write without that bit leaves it as it was.
- R7: At each window end, saved-next (offset 6) takes the window's first address, and saved-limit (offset 7) takes the end address with the limit's bit 31. When a queued window is taken, saved-start (8) and saved-stop (9) capture it.
- R8: In device-to-memory mode (control bit 0 = 0), a stream word carrying `dev_in_last` closes the window once it is stored. Saved-limit minus saved-next then gives the received byte count.
- R9: In memory-to-device mode, `dev_out_last` is high only on the final word of a window whose limit has bit 31 set.
- R10: A memory error response sets bus-exception (status bit 4), clears enable (status bit 1), and stops the transfer.
- R11: A control write with bit 4 (reset) clears enable, queue-valid, done and bus-exception, and aborts any transfer. The same write then applies its direction and any set bits. Bit 5 (buffer-init) also aborts the transfer.
- R12: Register map and bit positions:
  - Offset 0 is control on write and status on read, with status bits {bus-exception, done, queue-valid, enable, direction} at 4:0.
  - Offset 1 is the read-only live pointer.
  - Control write bits: 1 is set-enable, 2 is set-queue-valid, 3 is clear-done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Window-done interrupt |
| mem_req | output | 1 | Memory request, held until acknowledged or errored |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory request completed |
| mem_err | input | 1 | Memory request failed |
| dev_out_valid | output | 1 | Stream word to peripheral valid |
| dev_out_data | output | 32 | Stream word to peripheral |
| dev_out_last | output | 1 | Final word of a flagged window |
| dev_out_ready | input | 1 | Peripheral accepts word |
| dev_in_valid | input | 1 | Stream word from peripheral valid |
| dev_in_data | input | 32 | Stream word from peripheral |
| dev_in_last | input | 1 | End-of-packet marker |
| dev_in_ready | output | 1 | Engine accepts peripheral word |

## Verification
Register writes take effect at the next clock edge, and register reads are combinational. The bench therefore samples status one cycle after each write, at the falling edge. Transfer results have no fixed latency, because they depend on memory acknowledge and stream ready timing. The bench handles this by keeping expected stream words and memory writes in queues, and by popping an entry only in the cycle a handshake completes: a valid/ready pair, or an acknowledge with a write, seen just after the falling edge. Window-end state appears two cycles after the final handshake, once WRAP has run. The bench reads saved registers and status only after polling shows enable low.

// File: rtl/dma_chain_pkg.sv
`timescale 1ns/1ps
package dma_chain_pkg;

    localparam int unsigned RA_W = 4;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_PUSH  = 3'd2,
        S_PULL  = 3'd3,
        S_STORE = 3'd4,
        S_WRAP  = 3'd5
    } xfer_state_t;

    // register word offsets
    localparam logic [RA_W-1:0] OFS_CTRL   = 4'd0;
    localparam logic [RA_W-1:0] OFS_CUR    = 4'd1;
    localparam logic [RA_W-1:0] OFS_LOAD   = 4'd2;
    localparam logic [RA_W-1:0] OFS_LIMIT  = 4'd3;
    localparam logic [RA_W-1:0] OFS_START  = 4'd4;
    localparam logic [RA_W-1:0] OFS_STOP   = 4'd5;
    localparam logic [RA_W-1:0] OFS_SNEXT  = 4'd6;
    localparam logic [RA_W-1:0] OFS_SLIMIT = 4'd7;
    localparam logic [RA_W-1:0] OFS_SSTART = 4'd8;
    localparam logic [RA_W-1:0] OFS_SSTOP  = 4'd9;

    // control write bits
    localparam int unsigned CB_DIR     = 0;
    localparam int unsigned CB_SETEN   = 1;
    localparam int unsigned CB_SETCONT = 2;
    localparam int unsigned CB_CLRDONE = 3;
    localparam int unsigned CB_RESET   = 4;
    localparam int unsigned CB_INITBUF = 5;

endpackage

// File: rtl/dma_chain_span.sv
`timescale 1ns/1ps
module dma_chain_span #(
    parameter int unsigned AW   = 32,
    parameter int unsigned STEP = 4
) (
    input  logic [AW-1:0] ptr,
    input  logic [AW-1:0] bound,
    output logic          empty,
    output logic          final_beat
);
    // bit AW-1 of a bound is a flag, never part of the address
    logic [AW-1:0] p_addr;
    logic [AW-1:0] b_addr;
    logic [AW-1:0] p_after;

    always_comb begin
        p_addr     = {1'b0, ptr[AW-2:0]};
        b_addr     = {1'b0, bound[AW-2:0]};
        p_after    = p_addr + AW'(STEP);
        empty      = (p_addr >= b_addr);
        final_beat = (p_after >= b_addr);
    end
endmodule

// File: rtl/dma_chain_regs.sv
`timescale 1ns/1ps
module dma_chain_regs
    import dma_chain_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned STEP       = 4,
    parameter int unsigned ALIGN_BITS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [RA_W-1:0] addr,
    input  logic [AW-1:0]   wdata,
    output logic [AW-1:0]   rdata,
    input  logic            ev_step,
    input  logic            ev_wrap,
    input  logic            ev_buserr,
    output logic [AW-1:0]   cur_ptr,
    output logic [AW-1:0]   cur_lim,
    output logic [AW-1:0]   q_start,
    output logic [AW-1:0]   q_stop,
    output logic            dir,
    output logic            enable,
    output logic            cont_valid,
    output logic            done,
    output logic            abort
);
    localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << ALIGN_BITS) - AW'(1));
    localparam logic [AW-1:0] ADDR_MASK  = {1'b0, {(AW-1){1'b1}}};
    localparam logic [AW-1:0] PTR_MASK   = ALIGN_MASK & ADDR_MASK;

    logic [AW-1:0] cur_q, base_q, lim_q, start_q, stop_q;
    logic [AW-1:0] snext_q, slimit_q, sstart_q, sstop_q;
    logic          dir_q, en_q, cont_q, done_q, busx_q;
    logic          ctrl_wr;

    assign ctrl_wr = wr && (addr == OFS_CTRL);
    assign abort   = ctrl_wr && (wdata[CB_RESET] || wdata[CB_INITBUF]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            base_q   <= '0;
            lim_q    <= '0;
            start_q  <= '0;
            stop_q   <= '0;
            snext_q  <= '0;
            slimit_q <= '0;
            sstart_q <= '0;
            sstop_q  <= '0;
            dir_q    <= 1'b0;
            en_q     <= 1'b0;
            cont_q   <= 1'b0;
            done_q   <= 1'b0;
            busx_q   <= 1'b0;
        end else begin
            if (wr) begin
                case (addr)
                    OFS_CTRL: begin
                        if (wdata[CB_RESET]) begin
                            en_q   <= 1'b0;
                            cont_q <= 1'b0;
                            done_q <= 1'b0;
                            busx_q <= 1'b0;
                        end
                        dir_q <= wdata[CB_DIR];
                        if (wdata[CB_SETEN])   en_q   <= 1'b1;
                        if (wdata[CB_SETCONT]) cont_q <= 1'b1;
                        if (wdata[CB_CLRDONE]) done_q <= 1'b0;
                    end
                    OFS_LOAD: begin
                        cur_q  <= wdata & PTR_MASK;
                        base_q <= wdata & PTR_MASK;
                    end
                    OFS_LIMIT:  lim_q    <= wdata & ALIGN_MASK;
                    OFS_START:  start_q  <= wdata & PTR_MASK;
                    OFS_STOP:   stop_q   <= wdata & ALIGN_MASK;
                    OFS_SNEXT:  snext_q  <= wdata;
                    OFS_SLIMIT: slimit_q <= wdata;
                    OFS_SSTART: sstart_q <= wdata;
                    OFS_SSTOP:  sstop_q  <= wdata;
                    default: ;
                endcase
            end
            // hardware events take precedence over software writes
            if (ev_step) cur_q <= cur_q + AW'(STEP);
            if (ev_wrap) begin
                snext_q  <= base_q;
                slimit_q <= {lim_q[AW-1], cur_q[AW-2:0]};
                done_q   <= 1'b1;
                if (cont_q) begin
                    cur_q    <= start_q;
                    base_q   <= start_q;
                    lim_q    <= stop_q;
                    sstart_q <= start_q;
                    sstop_q  <= stop_q;
                    cont_q   <= 1'b0;
                end else begin
                    en_q <= 1'b0;
                end
            end
            if (ev_buserr) begin
                busx_q <= 1'b1;
                en_q   <= 1'b0;
            end
        end
    end

    always_comb begin
        case (addr)
            OFS_CTRL:   rdata = {{(AW-5){1'b0}}, busx_q, done_q, cont_q, en_q, dir_q};
            OFS_CUR:    rdata = cur_q;
            OFS_LOAD:   rdata = base_q;
            OFS_LIMIT:  rdata = lim_q;
            OFS_START:  rdata = start_q;
            OFS_STOP:   rdata = stop_q;
            OFS_SNEXT:  rdata = snext_q;
            OFS_SLIMIT: rdata = slimit_q;
            OFS_SSTART: rdata = sstart_q;
            OFS_SSTOP:  rdata = sstop_q;
            default:    rdata = '0;
        endcase
    end

    assign cur_ptr    = cur_q;
    assign cur_lim    = lim_q;
    assign q_start    = start_q;
    assign q_stop     = stop_q;
    assign dir        = dir_q;
    assign enable     = en_q;
    assign cont_valid = cont_q;
    assign done       = done_q;

    // R6
    wrap_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wrap |=> done_q);

    // R5
    final_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wrap && !cont_q && !wr) |=> (!en_q && !cont_q));

    // R4
    chain_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wrap && cont_q && !wr) |=> (!cont_q && cur_q == $past(start_q) && lim_q == $past(stop_q)));

    // R10
    buserr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_buserr |=> (busx_q && !en_q));

    // R11
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata[CB_RESET] && !wdata[CB_SETEN] && !wdata[CB_SETCONT])
        |=> (!en_q && !busx_q && !done_q && !cont_q));
endmodule

// File: rtl/dma_chain_fsm.sv
`timescale 1ns/1ps
module dma_chain_fsm
    import dma_chain_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned DW   = 32,
    parameter int unsigned STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          enable,
    input  logic          dir,
    input  logic          cont_valid,
    input  logic [AW-1:0] cur_ptr,
    input  logic [AW-1:0] cur_lim,
    input  logic [AW-1:0] q_start,
    input  logic [AW-1:0] q_stop,
    output logic          ev_step,
    output logic          ev_wrap,
    output logic          ev_buserr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          dev_out_valid,
    output logic [DW-1:0] dev_out_data,
    output logic          dev_out_last,
    input  logic          dev_out_ready,
    input  logic          dev_in_valid,
    input  logic [DW-1:0] dev_in_data,
    input  logic          dev_in_last,
    output logic          dev_in_ready
);
    localparam int unsigned NWIN = 2;

    xfer_state_t state_q, state_d;
    logic [DW-1:0] stage_q;
    logic          eop_q;

    // window 0 = active, window 1 = queued
    logic [AW-1:0] win_ptr   [NWIN];
    logic [AW-1:0] win_bound [NWIN];
    logic          win_empty [NWIN];
    logic          win_final [NWIN];

    assign win_ptr[0]   = cur_ptr;
    assign win_bound[0] = cur_lim;
    assign win_ptr[1]   = q_start;
    assign win_bound[1] = q_stop;

    for (genvar gi = 0; gi < NWIN; gi++) begin : g_span
        dma_chain_span #(.AW(AW), .STEP(STEP)) u_span (
            .ptr        (win_ptr[gi]),
            .bound      (win_bound[gi]),
            .empty      (win_empty[gi]),
            .final_beat (win_final[gi])
        );
    end

    logic cur_empty, cur_final, nxt_empty;
    assign cur_empty = win_empty[0];
    assign cur_final = win_final[0];
    assign nxt_empty = win_empty[1];

    xfer_state_t run_state;
    assign run_state = dir ? S_FETCH : S_PULL;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (enable) state_d = cur_empty ? S_WRAP : run_state;
            end
            S_FETCH: begin
                if (mem_err)      state_d = S_IDLE;
                else if (mem_ack) state_d = S_PUSH;
            end
            S_PUSH: begin
                if (dev_out_ready) state_d = cur_final ? S_WRAP : S_FETCH;
            end
            S_PULL: begin
                if (dev_in_valid) state_d = S_STORE;
            end
            S_STORE: begin
                if (mem_err)      state_d = S_IDLE;
                else if (mem_ack) state_d = (eop_q || cur_final) ? S_WRAP : S_PULL;
            end
            S_WRAP: begin
                if (cont_valid && !nxt_empty) state_d = run_state;
                else                          state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
        if (abort) state_d = S_IDLE;
    end

    // staging register for the word in flight
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            eop_q   <= 1'b0;
        end else if (abort) begin
            stage_q <= '0;
            eop_q   <= 1'b0;
        end else begin
            if (state_q == S_FETCH && mem_ack) stage_q <= mem_rdata;
            if (state_q == S_PULL && dev_in_valid) begin
                stage_q <= dev_in_data;
                eop_q   <= dev_in_last;
            end
        end
    end

    // outputs
    always_comb begin
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        dev_out_valid = 1'b0;
        dev_out_last  = 1'b0;
        dev_in_ready  = 1'b0;
        ev_step       = 1'b0;
        ev_wrap       = 1'b0;
        ev_buserr     = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_FETCH: begin
                mem_req   = 1'b1;
                ev_buserr = mem_err && !abort;
            end
            S_PUSH: begin
                dev_out_valid = 1'b1;
                dev_out_last  = cur_lim[AW-1] && cur_final;
                ev_step       = dev_out_ready && !abort;
            end
            S_PULL: begin
                dev_in_ready = 1'b1;
            end
            S_STORE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                ev_step   = mem_ack && !mem_err && !abort;
                ev_buserr = mem_err && !abort;
            end
            S_WRAP: begin
                ev_wrap = !abort;
            end
            default: ;
        endcase
    end

    assign mem_addr     = cur_ptr;
    assign mem_wdata    = stage_q;
    assign dev_out_data = stage_q;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err && !abort) |=> (mem_req && $stable(mem_addr)));

    // R4
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRAP && cont_valid && !nxt_empty && !abort)
        |=> (state_q == S_FETCH || state_q == S_PULL));

    // R9
    last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_out_last |-> (dev_out_valid && cur_lim[AW-1]));
endmodule

// File: rtl/dma_chain_channel.sv
`timescale 1ns/1ps
module dma_chain_channel
    import dma_chain_pkg::*;
#(
    parameter int unsigned ALIGN_BITS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            irq,
    output logic            mem_req,
    output logic            mem_we,
    output logic [31:0]     mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_ack,
    input  logic            mem_err,
    output logic            dev_out_valid,
    output logic [31:0]     dev_out_data,
    output logic            dev_out_last,
    input  logic            dev_out_ready,
    input  logic            dev_in_valid,
    input  logic [31:0]     dev_in_data,
    input  logic            dev_in_last,
    output logic            dev_in_ready
);
    localparam int unsigned AW   = 32;
    localparam int unsigned DW   = 32;
    localparam int unsigned STEP = DW / 8;

    logic          ev_step, ev_wrap, ev_buserr;
    logic [AW-1:0] cur_ptr, cur_lim, q_start, q_stop;
    logic          dir, enable, cont_valid, done, abort;

    dma_chain_regs #(.AW(AW), .STEP(STEP), .ALIGN_BITS(ALIGN_BITS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .ev_step    (ev_step),
        .ev_wrap    (ev_wrap),
        .ev_buserr  (ev_buserr),
        .cur_ptr    (cur_ptr),
        .cur_lim    (cur_lim),
        .q_start    (q_start),
        .q_stop     (q_stop),
        .dir        (dir),
        .enable     (enable),
        .cont_valid (cont_valid),
        .done       (done),
        .abort      (abort)
    );

    dma_chain_fsm #(.AW(AW), .DW(DW), .STEP(STEP)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .abort         (abort),
        .enable        (enable),
        .dir           (dir),
        .cont_valid    (cont_valid),
        .cur_ptr       (cur_ptr),
        .cur_lim       (cur_lim),
        .q_start       (q_start),
        .q_stop        (q_stop),
        .ev_step       (ev_step),
        .ev_wrap       (ev_wrap),
        .ev_buserr     (ev_buserr),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_ack       (mem_ack),
        .mem_err       (mem_err),
        .dev_out_valid (dev_out_valid),
        .dev_out_data  (dev_out_data),
        .dev_out_last  (dev_out_last),
        .dev_out_ready (dev_out_ready),
        .dev_in_valid  (dev_in_valid),
        .dev_in_data   (dev_in_data),
        .dev_in_last   (dev_in_last),
        .dev_in_ready  (dev_in_ready)
    );

    assign irq = done;

    // R6
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wrap && !reg_wr) |=> irq);
endmodule

// File: tb/dma_chain_channel_bench.sv
`timescale 1ns/1ps
module dma_chain_channel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack, mem_err;
    logic        dev_out_valid, dev_out_last;
    logic [31:0] dev_out_data;
    logic        dev_out_ready;
    logic        dev_in_valid = 1'b0;
    logic [31:0] dev_in_data = '0;
    logic        dev_in_last = 1'b0;
    logic        dev_in_ready;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [32:0] tx_q [$];
    logic [63:0] wr_q [$];

    always #2.5 clk = ~clk;

    dma_chain_channel u_dma_chain_channel (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_last(dev_out_last),
        .dev_out_ready(dev_out_ready),
        .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_last(dev_in_last),
        .dev_in_ready(dev_in_ready)
    );

    localparam logic [3:0] A_CTRL = 4'd0, A_CUR = 4'd1, A_LOAD = 4'd2, A_LIMIT = 4'd3,
                           A_START = 4'd4, A_STOP = 4'd5, A_SNEXT = 4'd6, A_SLIMIT = 4'd7,
                           A_SSTART = 4'd8, A_SSTOP = 4'd9;
    localparam logic [31:0] C_DIR = 32'h01, C_EN = 32'h02, C_CONT = 32'h04,
                            C_CLR = 32'h08, C_RST = 32'h10, C_INIT = 32'h20;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(A_CTRL, s);
            if (s[1] == 1'b0) break;
        end
    endtask

    task automatic rx_word(input logic [31:0] d, input logic last);
        dev_in_valid = 1'b1; dev_in_data = d; dev_in_last = last;
        while (!dev_in_ready) @(negedge clk);
        @(negedge clk);
        dev_in_valid = 1'b0; dev_in_last = 1'b0;
    endtask

    // memory responder: one-cycle ack, error above 0xF00
    initial begin
        mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack && !mem_err) begin
                if (mem_addr >= 32'h0000_0F00) mem_err = 1'b1;
                else begin
                    mem_ack = 1'b1;
                    mem_rdata = mem_word(mem_addr);
                end
            end else begin
                mem_ack = 1'b0; mem_err = 1'b0;
            end
        end
    end

    // stream back-pressure pattern
    initial begin
        dev_out_ready = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            dev_out_ready = (cyc % 3) != 0;
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (dev_out_valid && dev_out_ready) begin
                if (tx_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R3: actual unexpected word %h expected none", dev_out_data);
                end else begin
                    logic [32:0] e;
                    e = tx_q.pop_front();
                    chk(dev_out_data, e[31:0], "R3 stream word");
                    chk({31'd0, dev_out_last}, {31'd0, e[32]}, "R9 last flag");
                end
            end
            if (mem_ack && mem_we) begin
                if (wr_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R8: actual unexpected write %h expected none", mem_addr);
                end else begin
                    logic [63:0] e;
                    e = wr_q.pop_front();
                    chk(mem_addr, e[63:32], "R8 write addr");
                    chk(mem_wdata, e[31:0], "R8 write data");
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R12 reset state
        rd(A_CTRL, v);   chk(v, 32'h0, "R1 status after reset");
        rd(A_SLIMIT, v); chk(v, 32'h0, "R1 saved limit after reset");
        chk({31'd0, irq}, 32'h0, "R1 irq after reset");
        chk({30'd0, mem_req, dev_out_valid}, 32'h0, "R1 no request");

        // R2 alignment
        wr(A_LOAD, 32'h8000_123F);
        rd(A_CUR, v);  chk(v, 32'h0000_1230, "R2 pointer alignment");
        wr(A_STOP, 32'h8000_456C);
        rd(A_STOP, v); chk(v, 32'h8000_4560, "R2 stop keeps flag");

        // R6 queue-valid is set-only
        wr(A_CTRL, C_CONT);
        wr(A_CTRL, C_CLR);
        rd(A_CTRL, v); chk(v, 32'h4, "R6 queue-valid kept");
        wr(A_CTRL, C_RST);
        rd(A_CTRL, v); chk(v, 32'h0, "R11 reset clears queue-valid");

        // R3 R4 R9 transmit chain of two windows
        for (int i = 0; i < 4; i++) tx_q.push_back({1'b0, mem_word(32'h100 + 32'(4*i))});
        for (int i = 0; i < 8; i++) tx_q.push_back({i == 7, mem_word(32'h200 + 32'(4*i))});
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, C_RST | C_INIT | C_DIR);
        wr(A_LOAD, 32'h100);
        wr(A_LIMIT, 32'h110);
        wr(A_START, 32'h200);
        wr(A_STOP, 32'h8000_0220);
        wr(A_CTRL, C_EN | C_CONT | C_DIR);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(32'(tx_q.size()), 32'h0, "R3 all words delivered");
        rd(A_CTRL, v);   chk(v, 32'h9, "R5 status after chain");
        chk({31'd0, irq}, 32'h1, "R6 irq raised");
        rd(A_SNEXT, v);  chk(v, 32'h200, "R7 saved next");
        rd(A_SLIMIT, v); chk(v, 32'h8000_0220, "R7 saved limit flag");
        rd(A_SSTART, v); chk(v, 32'h200, "R7 saved start");
        rd(A_SSTOP, v);  chk(v, 32'h8000_0220, "R7 saved stop");
        rd(A_CUR, v);    chk(v, 32'h220, "R4 pointer at end");
        wr(A_CTRL, C_CLR | C_DIR);
        rd(A_CTRL, v);   chk(v, 32'h1, "R6 clear done");
        chk({31'd0, irq}, 32'h0, "R6 irq cleared");

        // R8 receive with early end
        for (int i = 0; i < 5; i++) wr_q.push_back({32'h400 + 32'(4*i), 32'hC0DE_0000 + 32'(i)});
        wr(A_CTRL, C_RST | C_INIT);
        wr(A_LOAD, 32'h400);
        wr(A_LIMIT, 32'h440);
        wr(A_CTRL, C_EN);
        for (int i = 0; i < 5; i++) rx_word(32'hC0DE_0000 + 32'(i), i == 4);
        wait_idle();
        chk(32'(wr_q.size()), 32'h0, "R8 all writes seen");
        rd(A_CTRL, v);   chk(v, 32'h8, "R5 status after early end");
        rd(A_SNEXT, v);  chk(v, 32'h400, "R8 saved next");
        rd(A_SLIMIT, v); chk(v, 32'h414, "R8 saved limit");

        // R4 receive chain
        for (int i = 0; i < 4; i++) wr_q.push_back({32'h500 + 32'(4*i), 32'hBEE0_0000 + 32'(i)});
        for (int i = 0; i < 4; i++) wr_q.push_back({32'h600 + 32'(4*i), 32'hBEE0_0004 + 32'(i)});
        wr(A_CTRL, C_RST | C_INIT);
        wr(A_LOAD, 32'h500);
        wr(A_LIMIT, 32'h510);
        wr(A_START, 32'h600);
        wr(A_STOP, 32'h610);
        wr(A_CTRL, C_EN | C_CONT);
        for (int i = 0; i < 8; i++) rx_word(32'hBEE0_0000 + 32'(i), 1'b0);
        wait_idle();
        chk(32'(wr_q.size()), 32'h0, "R4 chained writes seen");
        rd(A_SSTART, v); chk(v, 32'h600, "R7 saved start rx");
        rd(A_SLIMIT, v); chk(v, 32'h610, "R7 saved limit rx");
        rd(A_CTRL, v);   chk(v, 32'h8, "R5 status rx chain");

        // R10 bus error
        wr(A_CTRL, C_RST | C_INIT | C_DIR);
        wr(A_LOAD, 32'hF00);
        wr(A_LIMIT, 32'hF10);
        wr(A_CTRL, C_EN | C_DIR);
        wait_idle();
        rd(A_CTRL, v); chk(v, 32'h11, "R10 bus exception");
        chk(32'(tx_q.size()), 32'h0, "R10 no stream words");
        wr(A_CTRL, C_RST);
        rd(A_CTRL, v); chk(v, 32'h0, "R11 reset clears exception");

        // R5 empty window
        wr(A_CTRL, C_RST | C_DIR);
        wr(A_LOAD, 32'h700);
        wr(A_LIMIT, 32'h700);
        wr(A_CTRL, C_EN | C_DIR);
        wait_idle();
        rd(A_CTRL, v);   chk(v, 32'h9, "R5 empty window done");
        rd(A_SLIMIT, v); chk(v, 32'h700, "R7 empty saved limit");

        // R11 abort mid receive
        wr(A_CTRL, C_RST);
        wr(A_LOAD, 32'h800);
        wr(A_LIMIT, 32'h840);
        wr(A_CTRL, C_EN);
        wr_q.push_back({32'h800, 32'h0000_AB00});
        rx_word(32'h0000_AB00, 1'b0);
        repeat (3) @(negedge clk);
        wr(A_CTRL, C_RST);
        repeat (4) @(negedge clk);
        rd(A_CTRL, v); chk(v, 32'h0, "R11 abort status");
        chk({31'd0, dev_in_ready}, 32'h0, "R11 abort stops intake");
        rd(A_CUR, v);  chk(v, 32'h804, "R11 pointer after abort");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule